// File: doc/BRIEF.md
# Bus-Master DMA Channel Control Registers

This block holds the software-visible control state of one bus-master DMA channel for a disk controller: a command byte that starts and stops the channel, a status byte that reports activity, errors and drive interrupts, and a 32-bit pointer to the descriptor table in memory. Software reaches it through a byte-wide register port: one address, one write strobe and one data byte per cycle, with read data returned combinationally for the addressed byte.

On the other side it drives a descriptor-walking engine, which is not part of this block. On a start it hands the engine a one-cycle kick pulse and a current table pointer reloaded from the base register. On a stop it hands the engine a one-cycle cancel pulse. The engine reports back when it ends a transfer, when it hits an error, and when it steps to the next 8-byte descriptor. The drive's interrupt line passes through the block, and the block latches its rising edges into a status bit.

Top module: `bm_chan_regs`

## Requirements
- R1: After reset every register byte reads 0, the current pointer is 0, and the kick, cancel and interrupt outputs are low.
- R2: The command byte sits at offset 0. It stores only bit 0 (run) and bit 3 (direction). All other bits read as 0.
- R3: A command write that changes run from 0 to 1 reloads the current pointer from the base pointer and sets status bit 0 (active). If the channel was not active, it also raises the kick output for exactly the one cycle after the write.
- R4: A command write that changes run from 1 to 0 clears status bit 0 and raises the cancel output for exactly the one cycle after the write.
- R5: A command write that leaves run unchanged produces no kick and no cancel. It leaves active and the current pointer as they were, and it still stores the written direction bit.
- R6: The status byte sits at offset 2. Written bits 5 and 6 are stored as written. Bit 0 ignores writes. Bit 1 (error) and bit 2 (interrupt) are cleared where the written bit is 1 and otherwise held. Bits 3, 4 and 7 read as 0.
- R7: The interrupt output follows the drive interrupt input one cycle later. A rising edge of the input sets status bit 2, and the edge wins over a clearing write in the same cycle. A falling edge leaves bit 2 alone.
- R8: The base pointer occupies offsets 4 to 7, little-endian, one byte lane per offset. A write changes only its own lane, and bits 1:0 always read as 0.
- R9: An engine done pulse clears active and leaves the command byte unchanged. An engine advance pulse adds 8 to the current pointer. An engine error pulse sets status bit 1.
- R10: Reads of offsets 1 and 3 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Byte write strobe |
| regAddr | input | 3 | Byte offset for reads and writes |
| regWrData | input | 8 | Write data byte |
| regRdData | output | 8 | Read data for regAddr (combinational) |
| drvIrq | input | 1 | Interrupt level from the drive |
| irqOut | output | 1 | Interrupt level forwarded to the host |
| engDone | input | 1 | Engine finished with nothing pending |
| engError | input | 1 | Engine reports a transfer error |
| engAdvance | input | 1 | Engine stepped to the next descriptor |
| dmaKick | output | 1 | One-cycle start pulse to the engine |
| dmaCancel | output | 1 | One-cycle cancel pulse to the engine |
| curPtr | output | 32 | Current descriptor table pointer |

## Verification
The bench targets the run-bit edge rule. A design that acted on every write with run set would kick again, or reload the pointer and throw away the engine's progress, when software rewrites a 1. A design that acted on every write with run clear would send spurious cancels. The bench also targets the status write semantics: writing 1 to bit 0 must not set active, writing 0 to error or interrupt must not clear them, and a drive edge arriving together with a clearing write must not be lost. Pointer lanes are written one at a time so that a design that smears a byte across lanes, or lets bits 1:0 through, shows wrong read-back values.

// File: rtl/bm_chan_pkg.sv
package bm_chan_pkg;
  localparam int PTR_BYTES = 4;
  localparam int BYTE_W    = 8;

  // register byte offsets
  localparam int OFF_CMD  = 0;
  localparam int OFF_STAT = 2;
  localparam int OFF_PTR  = 4;

  // command bit positions
  localparam int CMD_RUN = 0;
  localparam int CMD_DIR = 3;

  // status bit positions
  localparam int ST_ACTIVE = 0;
  localparam int ST_ERR    = 1;
  localparam int ST_INT    = 2;
  localparam int ST_USR0   = 5;
  localparam int ST_USR1   = 6;

  typedef struct packed {
    logic                 cmdWr;
    logic                 statWr;
    logic [PTR_BYTES-1:0] ptrLaneWr;
    logic                 runRise;
    logic                 runFall;
    logic                 irqRise;
    logic [BYTE_W-1:0]    wrData;
  } ctrl_strobe_t;
endpackage

// File: rtl/bm_chan_ctrl.sv
module bm_chan_ctrl
  import bm_chan_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [BYTE_W-1:0] regWrData,
  input  logic              drvIrq,
  input  logic              runQ,
  input  logic              activeQ,
  output ctrl_strobe_t      strobe,
  output logic              dmaKick,
  output logic              dmaCancel,
  output logic              irqOut
);
  logic irqPrev;
  logic cmdHit;
  logic [PTR_BYTES-1:0] laneHit;

  assign cmdHit = regWrEn && (regAddr == ADDR_W'(OFF_CMD));

  for (genvar k = 0; k < PTR_BYTES; k++) begin : g_lane
    assign laneHit[k] = regWrEn && (regAddr == ADDR_W'(OFF_PTR + k));
  end

  always_comb begin
    strobe.cmdWr     = cmdHit;
    strobe.statWr    = regWrEn && (regAddr == ADDR_W'(OFF_STAT));
    strobe.ptrLaneWr = laneHit;
    strobe.runRise   = cmdHit && regWrData[CMD_RUN] && !runQ;
    strobe.runFall   = cmdHit && !regWrData[CMD_RUN] && runQ;
    strobe.irqRise   = drvIrq && !irqPrev;
    strobe.wrData    = regWrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqPrev   <= 1'b0;
      dmaKick   <= 1'b0;
      dmaCancel <= 1'b0;
    end else begin
      irqPrev   <= drvIrq;
      dmaKick   <= strobe.runRise && !activeQ;
      dmaCancel <= strobe.runFall;
    end
  end

  assign irqOut = irqPrev;
endmodule

// File: rtl/bm_chan_dp.sv
module bm_chan_dp
  import bm_chan_pkg::*;
#(
  parameter int ADDR_W     = 3,
  parameter int DESC_BYTES = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctrl_strobe_t                strobe,
  input  logic                        engDone,
  input  logic                        engError,
  input  logic                        engAdvance,
  input  logic [ADDR_W-1:0]           regAddr,
  output logic [BYTE_W-1:0]           regRdData,
  output logic                        runQ,
  output logic                        activeQ,
  output logic [BYTE_W-1:0]           cmdByte,
  output logic [BYTE_W-1:0]           statByte,
  output logic [PTR_BYTES*BYTE_W-1:0] basePtr,
  output logic [PTR_BYTES*BYTE_W-1:0] curPtr
);
  localparam int PTR_W = PTR_BYTES * BYTE_W;

  logic       dirQ;
  logic       errQ;
  logic       intQ;
  logic [1:0] usrQ;

  // command byte
  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ <= 1'b0;
      dirQ <= 1'b0;
    end else if (strobe.cmdWr) begin
      runQ <= strobe.wrData[CMD_RUN];
      dirQ <= strobe.wrData[CMD_DIR];
    end
  end

  // status byte: active is owned by hardware
  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      errQ    <= 1'b0;
      intQ    <= 1'b0;
      usrQ    <= 2'b00;
    end else begin
      if (strobe.runRise)
        activeQ <= 1'b1;
      else if (strobe.runFall || engDone)
        activeQ <= 1'b0;

      if (engError)
        errQ <= 1'b1;
      else if (strobe.statWr && strobe.wrData[ST_ERR])
        errQ <= 1'b0;

      if (strobe.irqRise)
        intQ <= 1'b1;
      else if (strobe.statWr && strobe.wrData[ST_INT])
        intQ <= 1'b0;

      if (strobe.statWr)
        usrQ <= {strobe.wrData[ST_USR1], strobe.wrData[ST_USR0]};
    end
  end

  // base pointer, one register per byte lane
  for (genvar k = 0; k < PTR_BYTES; k++) begin : g_base
    logic [BYTE_W-1:0] laneQ;
    always_ff @(posedge clk) begin
      if (!rstN)
        laneQ <= '0;
      else if (strobe.ptrLaneWr[k])
        laneQ <= strobe.wrData;
    end
    if (k == 0) begin : g_low
      assign basePtr[BYTE_W-1:0] = {laneQ[BYTE_W-1:2], 2'b00};
    end else begin : g_high
      assign basePtr[k*BYTE_W +: BYTE_W] = laneQ;
    end
  end

  // current pointer handed to the engine
  always_ff @(posedge clk) begin
    if (!rstN)
      curPtr <= '0;
    else if (strobe.runRise)
      curPtr <= basePtr;
    else if (engAdvance)
      curPtr <= curPtr + PTR_W'(DESC_BYTES);
  end

  always_comb begin
    cmdByte            = '0;
    cmdByte[CMD_RUN]   = runQ;
    cmdByte[CMD_DIR]   = dirQ;
    statByte           = '0;
    statByte[ST_ACTIVE] = activeQ;
    statByte[ST_ERR]   = errQ;
    statByte[ST_INT]   = intQ;
    statByte[ST_USR0]  = usrQ[0];
    statByte[ST_USR1]  = usrQ[1];
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == ADDR_W'(OFF_CMD))
      regRdData = cmdByte;
    else if (regAddr == ADDR_W'(OFF_STAT))
      regRdData = statByte;
    else
      for (int k = 0; k < PTR_BYTES; k++)
        if (regAddr == ADDR_W'(OFF_PTR + k))
          regRdData = basePtr[k*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/bm_chan_regs.sv
module bm_chan_regs
  import bm_chan_pkg::*;
#(
  parameter int ADDR_W     = 3,
  parameter int DESC_BYTES = 8,
  localparam int PTR_W     = PTR_BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [BYTE_W-1:0] regWrData,
  output logic [BYTE_W-1:0] regRdData,
  input  logic              drvIrq,
  output logic              irqOut,
  input  logic              engDone,
  input  logic              engError,
  input  logic              engAdvance,
  output logic              dmaKick,
  output logic              dmaCancel,
  output logic [PTR_W-1:0]  curPtr
);
  ctrl_strobe_t      strobe;
  logic              runQ;
  logic              activeQ;
  logic [BYTE_W-1:0] cmdByte;
  logic [BYTE_W-1:0] statByte;
  logic [PTR_W-1:0]  basePtr;

  bm_chan_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .drvIrq    (drvIrq),
    .runQ      (runQ),
    .activeQ   (activeQ),
    .strobe    (strobe),
    .dmaKick   (dmaKick),
    .dmaCancel (dmaCancel),
    .irqOut    (irqOut)
  );

  bm_chan_dp #(.ADDR_W(ADDR_W), .DESC_BYTES(DESC_BYTES)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .engDone    (engDone),
    .engError   (engError),
    .engAdvance (engAdvance),
    .regAddr    (regAddr),
    .regRdData  (regRdData),
    .runQ       (runQ),
    .activeQ    (activeQ),
    .cmdByte    (cmdByte),
    .statByte   (statByte),
    .basePtr    (basePtr),
    .curPtr     (curPtr)
  );
endmodule

// File: rtl/bm_chan_checker.sv
module bm_chan_checker #(
  parameter int ADDR_W = 3,
  parameter int PTR_W  = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [7:0]        regWrData,
  input logic              drvIrq,
  input logic              irqOut,
  input logic              dmaKick,
  input logic              dmaCancel,
  input logic [7:0]        cmdByte,
  input logic [7:0]        statByte,
  input logic [PTR_W-1:0]  basePtr,
  input logic [PTR_W-1:0]  curPtr
);
  assert_cmd_mask_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdByte & 8'hF6) == 8'h00);

  assert_kick_cause_R3: assert property (@(posedge clk) disable iff (!rstN)
    dmaKick |-> ($past(regWrEn && regAddr == '0 && regWrData[0]) && !$past(cmdByte[0])));

  assert_active_rise_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statByte[0]) |-> dmaKick);

  assert_cancel_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    dmaCancel |-> !statByte[0]);

  assert_pulse_excl_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(dmaKick && dmaCancel));

  assert_stat_reserved_R6: assert property (@(posedge clk) disable iff (!rstN)
    (statByte & 8'h98) == 8'h00);

  assert_irq_latch_R7: assert property (@(posedge clk) disable iff (!rstN)
    (drvIrq && !irqOut) |=> statByte[2]);

  assert_irq_drop_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(drvIrq) |=> !irqOut);

  assert_ptr_align_R8: assert property (@(posedge clk) disable iff (!rstN)
    basePtr[1:0] == 2'b00 && curPtr[1:0] == 2'b00);
endmodule

bind bm_chan_regs bm_chan_checker #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) checker_i (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .regWrData (regWrData),
  .drvIrq    (drvIrq),
  .irqOut    (irqOut),
  .dmaKick   (dmaKick),
  .dmaCancel (dmaCancel),
  .cmdByte   (cmdByte),
  .statByte  (statByte),
  .basePtr   (basePtr),
  .curPtr    (curPtr)
);

// File: tb/bm_chan_regs_tb.sv
module bm_chan_regs_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData;
  logic        drvIrq = 1'b0;
  logic        irqOut;
  logic        engDone = 1'b0;
  logic        engError = 1'b0;
  logic        engAdvance = 1'b0;
  logic        dmaKick;
  logic        dmaCancel;
  logic [31:0] curPtr;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  bm_chan_regs dut_i (.*);

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic wrByte(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdByte(input logic [2:0] a, output logic [7:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic engPulse(input int which);
    @(negedge clk);
    engDone = (which == 0); engError = (which == 1); engAdvance = (which == 2);
    @(negedge clk);
    engDone = 1'b0; engError = 1'b0; engAdvance = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    for (int a = 0; a < 8; a++) begin
      rdByte(3'(a), d);
      check("R1", $sformatf("byte %0d after reset", a), d, 0);
    end
    check("R1", "curPtr after reset", curPtr, 0);
    check("R1", "kick/cancel/irq after reset", {dmaKick, dmaCancel, irqOut}, 0);
  endtask

  task automatic t_pointer;
    logic [7:0] d;
    wrByte(4, 8'hFF); wrByte(5, 8'h34); wrByte(6, 8'h56); wrByte(7, 8'h78);
    rdByte(4, d); check("R8", "lane 0 low bits forced", d, 8'hFC);
    rdByte(5, d); check("R8", "lane 1", d, 8'h34);
    rdByte(7, d); check("R8", "lane 3", d, 8'h78);
    wrByte(5, 8'hAB);
    rdByte(4, d); check("R8", "lane 0 untouched by lane 1 write", d, 8'hFC);
    rdByte(5, d); check("R8", "lane 1 rewritten", d, 8'hAB);
    rdByte(6, d); check("R8", "lane 2 untouched", d, 8'h56);
    rdByte(1, d); check("R10", "offset 1 reads zero", d, 0);
    rdByte(3, d); check("R10", "offset 3 reads zero", d, 0);
  endtask

  task automatic t_start;
    logic [7:0] d;
    wrByte(0, 8'h09);
    check("R3", "kick after run rise", dmaKick, 1);
    check("R3", "cancel after run rise", dmaCancel, 0);
    check("R3", "curPtr reloaded", curPtr, 32'h7856ABFC);
    rdByte(2, d); check("R3", "active set", d[0], 1);
    @(negedge clk);
    check("R3", "kick lasts one cycle", dmaKick, 0);
    rdByte(0, d); check("R2", "command keeps bits 0 and 3", d, 8'h09);
    engPulse(2);
    check("R9", "advance adds 8", curPtr, 32'h7856AC04);
    wrByte(0, 8'hF7);
    check("R5", "no kick on repeated run", {dmaKick, dmaCancel}, 0);
    rdByte(0, d); check("R2", "mask on 0xF7", d, 8'h01);
    check("R5", "curPtr kept on repeated run", curPtr, 32'h7856AC04);
    rdByte(2, d); check("R5", "active kept on repeated run", d[0], 1);
  endtask

  task automatic t_stop;
    logic [7:0] d;
    wrByte(0, 8'h00);
    check("R4", "cancel after run fall", dmaCancel, 1);
    check("R4", "no kick on run fall", dmaKick, 0);
    rdByte(2, d); check("R4", "active cleared", d[0], 0);
    @(negedge clk);
    check("R4", "cancel lasts one cycle", dmaCancel, 0);
    wrByte(0, 8'h08);
    check("R5", "no cancel on repeated stop", {dmaKick, dmaCancel}, 0);
    rdByte(0, d); check("R5", "direction stored on repeat", d, 8'h08);
  endtask

  task automatic t_engine_done;
    logic [7:0] d;
    wrByte(0, 8'h01);
    check("R3", "kick on second start", dmaKick, 1);
    engPulse(0);
    rdByte(2, d); check("R9", "done clears active", d[0], 0);
    rdByte(0, d); check("R9", "done keeps command", d, 8'h01);
    wrByte(0, 8'h01);
    check("R5", "no kick after done with run held", dmaKick, 0);
  endtask

  task automatic t_status;
    logic [7:0] d;
    wrByte(0, 8'h00); wrByte(0, 8'h01);
    engPulse(1);
    rdByte(2, d); check("R9", "error pulse sets bit 1", d, 8'h03);
    @(negedge clk); drvIrq = 1'b1;
    @(negedge clk);
    rdByte(2, d); check("R7", "rise sets bit 2", d, 8'h07);
    wrByte(2, 8'hE2);
    rdByte(2, d); check("R6", "clear error, keep int, set user bits", d, 8'h65);
    wrByte(2, 8'h18);
    rdByte(2, d); check("R6", "zero writes hold, reserved stay 0", d, 8'h05);
    wrByte(2, 8'h04);
    rdByte(2, d); check("R6", "clear int, active ignores write", d, 8'h01);
    wrByte(0, 8'h00);
    wrByte(2, 8'h01);
    rdByte(2, d); check("R6", "writing 1 to active has no effect", d, 8'h00);
  endtask

  task automatic t_irq;
    logic [7:0] d;
    check("R7", "irqOut follows high input", irqOut, 1);
    @(negedge clk); drvIrq = 1'b0;
    @(negedge clk);
    check("R7", "irqOut follows fall", irqOut, 0);
    rdByte(2, d); check("R7", "fall leaves bit 2", d[2], 0);
    // rise and clearing write in the same cycle
    @(negedge clk);
    drvIrq = 1'b1; regWrEn = 1'b1; regAddr = 3'd2; regWrData = 8'h04;
    @(negedge clk);
    regWrEn = 1'b0;
    rdByte(2, d); check("R7", "rise beats clear", d[2], 1);
    check("R7", "irqOut high after rise", irqOut, 1);
    @(negedge clk); drvIrq = 1'b0;
    @(negedge clk);
    rdByte(2, d); check("R7", "bit 2 held after fall", d[2], 1);
    check("R7", "irqOut low after fall", irqOut, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rstN = 1'b1;
    t_reset;
    t_pointer;
    t_start;
    t_stop;
    t_engine_done;
    t_status;
    t_irq;
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule